// File: doc/BRIEF.md
# Ethernet MAC Host-Side Frame Buffer

This block sits between a processor and the line side of a simple Ethernet MAC. Software moves whole frames through a single 32-bit data port. Writes fill a transmit buffer. Reads drain a receive buffer in which every frame is stored behind a length word. Software fills the transmit buffer with a length word and the frame bytes, then pulses a start input. A pending flag stays high while the frame is sent and drops by itself once the buffer is free for the next frame.

On the receive side, a frame counter tells software how many complete frames are waiting. A one-cycle request towards a DMA controller marks the moment a new complete frame is available. Software, or the DMA engine, reads the length word first and then knows how many further words belong to that frame. Frames with a bad check sequence can be discarded. Frames that do not fit are dropped whole, and a sticky overrun flag records each such loss.

The line side uses plain byte streams. Incoming bytes arrive with valid, last and bad-check-sequence markers. Outgoing bytes use a valid/ready handshake and carry a last marker.

Top module: `eth_host_fifo`

## Requirements
- R1: While reset is low, the frame count, the pending flag, both DMA requests, both overrun flags and the outgoing byte valid are all 0.
- R2: Each received frame reads out as a length word followed by ceil(n/4) data words. The length word holds the byte count n in bits [15:0] and zero in bits [31:16]. Byte k of the frame sits in data word k/4 at bits [8*(k%4)+7 : 8*(k%4)]. Unused lanes of the last word are zero.
- R3: The frame count rises by one in the cycle after the last byte of an accepted frame, and falls by one when the last word of a frame is popped. A pop while the count is zero is ignored and does not move the read position.
- R4: dma_rx_req is a single-cycle pulse. It is raised in the cycle after a frame is accepted, and in the cycle after the last word of a frame is popped if at least one complete frame is still waiting. It stays low when the last waiting frame has been read.
- R5: When rx_drop_bad is 1, a frame whose last byte carries rxl_fcs_bad leaves no trace: the count does not change and the next frame reads correctly. When rx_drop_bad is 0, such a frame is kept like any other.
- R6: A frame that would exceed the receive capacity (RX_BYTES/4 words, length words included) is dropped whole. Frames already stored stay intact, and rx_overrun becomes 1 and stays 1 until a flush or a reset.
- R7: A one-cycle rx_flush empties the receive buffer, sets the count to 0 and clears rx_overrun. Later frames are stored and read normally.
- R8: While rx_enable is 0, incoming bytes are ignored.
- R9: The transmit buffer is filled with a length word (byte count in bits [15:0]) and then the data words, using the byte lanes of R2. A tx_start pulse sets tx_pending in the next cycle. The bytes then leave in order, with txl_last on the final byte. tx_pending clears after the final byte has been accepted, and the buffer then refills from its start.
- R10: Data-port writes while tx_pending is 1 are ignored. tx_overrun becomes 1 and stays 1 until reset.
- R11: dma_tx_req is a single-cycle pulse in the cycle after the transmit buffer becomes empty at the end of a frame, together with tx_pending going low.
- R12: While tx_enable is 0, a pending frame is held: txl_valid stays 0 and no byte is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dat_wr | input | 1 | Push dat_wdata into the transmit buffer |
| dat_wdata | input | 32 | Transmit word |
| dat_rd | input | 1 | Pop the word shown on dat_rdata |
| dat_rdata | output | 32 | Current receive word |
| tx_start | input | 1 | Pulse: start sending the buffered frame |
| tx_pending | output | 1 | Frame being sent; clears itself when done |
| tx_enable | input | 1 | Transmitter enable |
| rx_enable | input | 1 | Receiver enable |
| rx_flush | input | 1 | Pulse: empty the receive buffer |
| rx_drop_bad | input | 1 | Discard frames marked bad |
| rx_frames | output | $clog2(RX_BYTES/4)+1 | Complete frames waiting |
| tx_overrun | output | 1 | Sticky: write refused while pending |
| rx_overrun | output | 1 | Sticky: frame dropped for lack of space |
| dma_tx_req | output | 1 | Single transfer request, transmit |
| dma_rx_req | output | 1 | Single transfer request, receive |
| rxl_valid | input | 1 | Incoming byte valid |
| rxl_data | input | 8 | Incoming byte |
| rxl_last | input | 1 | Last byte of incoming frame |
| rxl_fcs_bad | input | 1 | Frame check failed (with last) |
| txl_valid | output | 1 | Outgoing byte valid |
| txl_data | output | 8 | Outgoing byte |
| txl_last | output | 1 | Final byte of outgoing frame |
| txl_ready | input | 1 | Line side accepts the byte |

## Verification
Receive frames of 10, 5, 8, 4 and 3 bytes are used so that every partial-last-word lane count shows up. This separates correct padding and length rounding from off-by-one word counts. Two frames are queued before reading, so a request that should fire after the first read can be told apart from one that must stay quiet after the second. Bad-check-sequence frames are sent with dropping on and off, and a frame is sent while the receiver is disabled. A run of 400-byte frames fills the buffer exactly to the point where the sixth frame must roll back, which tests the rollback against the frames already stored. Transmit frames are sent with random back-pressure, with the transmitter held disabled while a refused write lands, and then again to show that the buffer refills from its start.

// File: rtl/eth_hf_pkg.sv
package eth_hf_pkg;
   localparam int WORD_W = 32;
   localparam int BYTE_W = 8;
   localparam int LEN_W  = 16;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_LOAD = 2'd1,
      TX_SEND = 2'd2
   } tx_phase_t;

   function automatic logic [WORD_W-1:0] len_word(input logic [LEN_W-1:0] n);
      return {{(WORD_W-LEN_W){1'b0}}, n};
   endfunction
endpackage

// File: rtl/eth_hf_ram.sv
module eth_hf_ram #(
   parameter int W     = 32,
   parameter int DEPTH = 512,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we0,
   input  logic [AW-1:0] wa0,
   input  logic [W-1:0]  wd0,
   input  logic          we1,
   input  logic [AW-1:0] wa1,
   input  logic [W-1:0]  wd1,
   input  logic [AW-1:0] ra,
   output logic [W-1:0]  rd
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("eth_hf_ram: DEPTH must be a power of two >= 4");
   end

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we0) mem[wa0] <= wd0;
      if (we1) mem[wa1] <= wd1;
   end

   assign rd = mem[ra];
endmodule

// File: rtl/eth_hf_rx.sv
module eth_hf_rx import eth_hf_pkg::*; #(
   parameter int  DEPTH     = 512,
   parameter bit  LSB_FIRST = 1'b1,
   localparam int AW        = $clog2(DEPTH),
   localparam int PW        = AW + 1,
   localparam int CW        = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              flush,
   input  logic              drop_bad,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_last,
   input  logic              in_bad,
   input  logic              rd,
   output logic [WORD_W-1:0] rdata,
   output logic [CW-1:0]     pkt_cnt,
   output logic              ovr,
   output logic              dma_req
);
   localparam logic [PW-1:0] FULL = PW'(DEPTH);

   logic [PW-1:0]     wp, cp, rp, base, wp_n, cp_n;
   logic              infrm, drop, inf_n, drp_n, drp_now, ovr_n;
   logic [1:0]        bcnt, bcnt_n, lane;
   logic [WORD_W-1:0] pack, pack_n;
   logic [LEN_W-1:0]  flen, len_n, left, left_n;
   logic              acc, wr_d, wr_h, commit, rd_ok, done;
   logic [16:0]       hsum;
   logic [CW-1:0]     cnt_n;

   if (LSB_FIRST) begin : g_lsb
      assign lane = bcnt;
   end else begin : g_msb
      assign lane = 2'd3 - bcnt;
   end

   assign acc = en && in_valid;

   // write side: header slot reserved at cp, data from cp+1, rollback to cp
   always_comb begin
      wp_n = wp; cp_n = cp; inf_n = infrm; drp_n = drop; bcnt_n = bcnt;
      pack_n = pack; len_n = flen; ovr_n = ovr; wr_d = 1'b0; wr_h = 1'b0;
      commit = 1'b0; drp_now = 1'b0;
      base = infrm ? wp : wp + PW'(1);
      if (acc) begin
         drp_now = infrm ? drop : ((wp - rp) == FULL);
         inf_n   = !in_last;
         len_n   = (infrm ? flen : '0) + LEN_W'(1);
         bcnt_n  = in_last ? 2'd0 : bcnt + 2'd1;
         pack_n  = ((bcnt == 2'd0) ? '0 : pack) | (WORD_W'(in_data) << {lane, 3'b000});
         wp_n    = base;
         if (!drp_now && (bcnt == 2'd3 || in_last)) begin
            if ((base - rp) == FULL) drp_now = 1'b1;
            else begin
               wr_d = 1'b1;
               wp_n = base + PW'(1);
            end
         end
         drp_n = drp_now && !in_last;
         ovr_n = ovr | drp_now;
         if (drp_now || (in_last && in_bad && drop_bad)) begin
            wp_n = cp;
            wr_d = 1'b0;
         end else if (in_last) begin
            wr_h   = 1'b1;
            cp_n   = wp_n;
            commit = 1'b1;
         end
      end
   end

   // read side: the length word tells how many data words follow
   assign rd_ok = rd && (pkt_cnt != '0);
   assign hsum  = {1'b0, rdata[LEN_W-1:0]} + 17'd3;

   always_comb begin
      left_n = left;
      done   = 1'b0;
      if (rd_ok) begin
         if (left == '0) begin
            left_n = {1'b0, hsum[16:2]};
            done   = (hsum[16:2] == '0);
         end else begin
            left_n = left - LEN_W'(1);
            done   = (left == LEN_W'(1));
         end
      end
   end

   assign cnt_n = pkt_cnt + CW'(commit) - CW'(done);

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp <= '0; cp <= '0; rp <= '0; infrm <= 1'b0; drop <= 1'b0;
         bcnt <= '0; pack <= '0; flen <= '0; left <= '0;
         pkt_cnt <= '0; ovr <= 1'b0; dma_req <= 1'b0;
      end else begin
         wp <= wp_n; cp <= cp_n; infrm <= inf_n; drop <= drp_n;
         bcnt <= bcnt_n; pack <= pack_n; flen <= len_n; ovr <= ovr_n;
         rp <= rp + PW'(rd_ok);
         left <= left_n;
         pkt_cnt <= cnt_n;
         dma_req <= commit || (done && cnt_n != '0);
      end
   end

   eth_hf_ram #(.W(WORD_W), .DEPTH(DEPTH)) i_mem (
      .clk(clk),
      .we0(wr_d), .wa0(base[AW-1:0]), .wd0(pack_n),
      .we1(wr_h), .wa1(cp[AW-1:0]),   .wd1(len_word(len_n)),
      .ra(rp[AW-1:0]), .rd(rdata)
   );

   assert_rd_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && pkt_cnt == '0 && !flush) |=> $stable(rp));
   assert_req_has_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> pkt_cnt != '0);
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wp - rp) <= FULL);
   assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !flush) |=> ovr);
   assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (pkt_cnt == '0 && !ovr));
endmodule

// File: rtl/eth_hf_tx.sv
module eth_hf_tx import eth_hf_pkg::*; #(
   parameter int  DEPTH     = 512,
   parameter bit  LSB_FIRST = 1'b1,
   localparam int AW        = $clog2(DEPTH),
   localparam int PW        = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              go,
   output logic              busy,
   output logic              ovr,
   output logic              dma_req,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_last,
   input  logic              out_ready
);
   localparam logic [PW-1:0] FULL = PW'(DEPTH);

   tx_phase_t         phase, phase_n;
   logic [PW-1:0]     wp, wp_n;
   logic [AW-1:0]     rp, rp_n;
   logic [LEN_W-1:0]  rem, rem_n;
   logic [1:0]        bsel, bsel_n, lane;
   logic              wr_ok, fin, ovr_n;
   logic [WORD_W-1:0] rdata;

   if (LSB_FIRST) begin : g_lsb
      assign lane = bsel;
   end else begin : g_msb
      assign lane = 2'd3 - bsel;
   end

   assign busy      = (phase != TX_IDLE);
   assign wr_ok     = wr && !busy && (wp != FULL);
   assign out_valid = en && (phase == TX_SEND);
   assign out_data  = rdata[{lane, 3'b000} +: BYTE_W];
   assign out_last  = (rem == LEN_W'(1));

   always_comb begin
      phase_n = phase; rp_n = rp; rem_n = rem; bsel_n = bsel;
      wp_n = wr_ok ? wp + PW'(1) : wp;
      ovr_n = ovr | (wr && !wr_ok);
      fin = 1'b0;
      unique case (phase)
         TX_IDLE: if (go && wp != '0) begin
            phase_n = TX_LOAD;
            rp_n    = '0;
         end
         TX_LOAD: if (en) begin
            rem_n  = rdata[LEN_W-1:0];
            rp_n   = AW'(1);
            bsel_n = '0;
            if (rdata[LEN_W-1:0] == '0) fin = 1'b1;
            else phase_n = TX_SEND;
         end
         TX_SEND: if (out_valid && out_ready) begin
            rem_n  = rem - LEN_W'(1);
            bsel_n = bsel + 2'd1;
            if (bsel == 2'd3) rp_n = rp + AW'(1);
            if (rem == LEN_W'(1)) fin = 1'b1;
         end
         default: ;
      endcase
      if (fin) begin
         phase_n = TX_IDLE;
         wp_n    = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= TX_IDLE; wp <= '0; rp <= '0; rem <= '0; bsel <= '0;
         ovr <= 1'b0; dma_req <= 1'b0;
      end else begin
         phase <= phase_n; wp <= wp_n; rp <= rp_n; rem <= rem_n; bsel <= bsel_n;
         ovr <= ovr_n; dma_req <= fin;
      end
   end

   eth_hf_ram #(.W(WORD_W), .DEPTH(DEPTH)) i_mem (
      .clk(clk),
      .we0(wr_ok), .wa0(wp[AW-1:0]), .wd0(wdata),
      .we1(1'b0),  .wa1('0),          .wd1('0),
      .ra(rp), .rd(rdata)
   );

   assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == TX_SEND && !(out_valid && out_ready && out_last)) |=> busy);
   assert_wr_busy_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && phase == TX_SEND && !(out_valid && out_ready && out_last)) |=> $stable(wp));
   assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |=> ovr);
   assert_req_when_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> (!busy && wp == '0));
   assert_hold_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && busy) |=> ($stable(rem) && $stable(rp)));
endmodule

// File: rtl/eth_host_fifo.sv
module eth_host_fifo import eth_hf_pkg::*; #(
   parameter int  TX_BYTES  = 2048,
   parameter int  RX_BYTES  = 2048,
   parameter bit  LSB_FIRST = 1'b1,
   localparam int TXD       = TX_BYTES / 4,
   localparam int RXD       = RX_BYTES / 4,
   localparam int RXCW      = $clog2(RXD) + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dat_wr,
   input  logic [31:0]     dat_wdata,
   input  logic            dat_rd,
   output logic [31:0]     dat_rdata,
   input  logic            tx_start,
   output logic            tx_pending,
   input  logic            tx_enable,
   input  logic            rx_enable,
   input  logic            rx_flush,
   input  logic            rx_drop_bad,
   output logic [RXCW-1:0] rx_frames,
   output logic            tx_overrun,
   output logic            rx_overrun,
   output logic            dma_tx_req,
   output logic            dma_rx_req,
   input  logic            rxl_valid,
   input  logic [7:0]      rxl_data,
   input  logic            rxl_last,
   input  logic            rxl_fcs_bad,
   output logic            txl_valid,
   output logic [7:0]      txl_data,
   output logic            txl_last,
   input  logic            txl_ready
);
   if (TX_BYTES % 4 != 0 || RX_BYTES % 4 != 0) begin : g_bad_size
      $error("eth_host_fifo: buffer sizes must be whole words");
   end

   eth_hf_tx #(.DEPTH(TXD), .LSB_FIRST(LSB_FIRST)) i_tx (
      .clk(clk), .rst_n(rst_n), .en(tx_enable),
      .wr(dat_wr), .wdata(dat_wdata), .go(tx_start),
      .busy(tx_pending), .ovr(tx_overrun), .dma_req(dma_tx_req),
      .out_valid(txl_valid), .out_data(txl_data), .out_last(txl_last),
      .out_ready(txl_ready)
   );

   eth_hf_rx #(.DEPTH(RXD), .LSB_FIRST(LSB_FIRST)) i_rx (
      .clk(clk), .rst_n(rst_n), .en(rx_enable), .flush(rx_flush),
      .drop_bad(rx_drop_bad),
      .in_valid(rxl_valid), .in_data(rxl_data), .in_last(rxl_last),
      .in_bad(rxl_fcs_bad),
      .rd(dat_rd), .rdata(dat_rdata), .pkt_cnt(rx_frames),
      .ovr(rx_overrun), .dma_req(dma_rx_req)
   );
endmodule

// File: tb/test_eth_host_fifo.sv
module test_eth_host_fifo;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n, dat_wr, dat_rd, tx_start, tx_enable, rx_enable;
   logic        rx_flush, rx_drop_bad, rxl_valid, rxl_last, rxl_fcs_bad;
   logic [31:0] dat_wdata, dat_rdata;
   logic [7:0]  rxl_data, txl_data;
   logic [9:0]  rx_frames;
   logic        tx_pending, tx_overrun, rx_overrun, dma_tx_req, dma_rx_req;
   logic        txl_valid, txl_last;
   logic        txl_ready = 1'b1;

   eth_host_fifo i_eth_host_fifo (.*);

   int checks = 0, errors = 0, tx_req_seen = 0;
   bit finished = 1'b0, stall_en = 1'b0;
   int rx_q[$];
   int tx_q[$];
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: outgoing bytes against the scoreboard, back-pressure generator
   always @(negedge clk) begin
      if (rst_n && txl_valid && txl_ready) begin
         if (tx_q.size() == 0) chk(1'b0, "R9", "unexpected tx byte", txl_data, 0);
         else begin
            int e;
            e = tx_q.pop_front();
            chk({txl_last, txl_data} == e[8:0], "R9", "tx byte/last",
                {txl_last, txl_data}, e);
         end
      end
      if (rst_n && dma_tx_req) tx_req_seen++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      txl_ready = stall_en ? lfsr[0] : 1'b1;
   end

   task automatic rx_frame(input int n, input int seed, input bit bad, input bit keep);
      logic [31:0] w;
      w = '0;
      if (keep) rx_q.push_back(n);
      for (int i = 0; i < n; i++) begin
         logic [7:0] b;
         b = 8'(seed + i * 7);
         @(negedge clk);
         rxl_valid = 1'b1; rxl_data = b;
         rxl_last = (i == n - 1); rxl_fcs_bad = bad && (i == n - 1);
         w[8*(i%4) +: 8] = b;
         if (i % 4 == 3 || i == n - 1) begin
            if (keep) rx_q.push_back(int'(w));
            w = '0;
         end
      end
      @(negedge clk);
      rxl_valid = 1'b0; rxl_last = 1'b0; rxl_fcs_bad = 1'b0;
   endtask

   task automatic rd_frame(input string req);
      int nw;
      nw = 1 + (rx_q[0] + 3) / 4;
      for (int i = 0; i < nw; i++) begin
         int e;
         @(negedge clk);
         e = rx_q.pop_front();
         chk(dat_rdata == 32'(e), req, "rx word", dat_rdata, e);
         dat_rd = 1'b1;
      end
      @(negedge clk);
      dat_rd = 1'b0;
   endtask

   task automatic tx_load(input int n, input int seed);
      logic [31:0] w;
      w = '0;
      @(negedge clk);
      dat_wr = 1'b1; dat_wdata = 32'(n);
      for (int i = 0; i < n; i++) begin
         logic [7:0] b;
         b = 8'(seed + i * 5);
         tx_q.push_back(int'({(i == n - 1), b}));
         w[8*(i%4) +: 8] = b;
         if (i % 4 == 3 || i == n - 1) begin
            @(negedge clk);
            dat_wdata = w;
            w = '0;
         end
      end
      @(negedge clk);
      dat_wr = 1'b0;
   endtask

   task automatic tx_go();
      @(negedge clk); tx_start = 1'b1;
      @(negedge clk); tx_start = 1'b0;
   endtask

   task automatic tx_wait();
      while (tx_pending) @(negedge clk);
      @(posedge clk); #1;
   endtask

   initial begin
      int base;
      rst_n = 1'b0; dat_wr = 0; dat_rd = 0; tx_start = 0; dat_wdata = '0;
      tx_enable = 1; rx_enable = 1; rx_flush = 0; rx_drop_bad = 1;
      rxl_valid = 0; rxl_data = '0; rxl_last = 0; rxl_fcs_bad = 0;
      repeat (3) @(negedge clk);
      chk(rx_frames == 0 && !tx_pending && !dma_rx_req && !dma_tx_req &&
          !rx_overrun && !tx_overrun && !txl_valid, "R1", "reset state",
          {rx_frames, tx_pending, dma_rx_req, dma_tx_req, rx_overrun, tx_overrun}, 0);
      rst_n = 1'b1;

      // two frames queued, then read back
      rx_frame(10, 8'h11, 0, 1);
      chk(rx_frames == 1, "R3", "count after first frame", rx_frames, 1);
      chk(dma_rx_req == 1, "R4", "req after accept", dma_rx_req, 1);
      rx_frame(5, 8'h40, 0, 1);
      chk(rx_frames == 2, "R3", "count after second frame", rx_frames, 2);
      rd_frame("R2");
      chk(rx_frames == 1, "R3", "count after one read", rx_frames, 1);
      chk(dma_rx_req == 1, "R4", "req while frames remain", dma_rx_req, 1);
      rd_frame("R2");
      chk(rx_frames == 0, "R3", "count after both read", rx_frames, 0);
      chk(dma_rx_req == 0, "R4", "no req when none remain", dma_rx_req, 0);

      // pops while empty must not move the read position
      @(negedge clk); dat_rd = 1'b1;
      repeat (3) @(negedge clk);
      dat_rd = 1'b0;
      chk(rx_frames == 0, "R3", "count after empty pops", rx_frames, 0);
      rx_frame(8, 8'h77, 0, 1);
      rd_frame("R3");

      // bad check sequence, drop on then off
      rx_frame(12, 8'h23, 1, 0);
      chk(rx_frames == 0, "R5", "bad frame dropped", rx_frames, 0);
      rx_frame(7, 8'h5A, 0, 1);
      rd_frame("R5");
      rx_drop_bad = 1'b0;
      rx_frame(6, 8'h31, 1, 1);
      chk(rx_frames == 1, "R5", "bad frame kept", rx_frames, 1);
      rd_frame("R5");
      rx_drop_bad = 1'b1;

      // receiver disabled
      rx_enable = 1'b0;
      rx_frame(9, 8'h99, 0, 0);
      chk(rx_frames == 0, "R8", "disabled receiver", rx_frames, 0);
      rx_enable = 1'b1;
      rx_frame(3, 8'h12, 0, 1);
      rd_frame("R8");

      // fill to capacity, sixth frame must be dropped
      for (int k = 0; k < 5; k++) rx_frame(400, k * 3, 0, 1);
      chk(rx_frames == 5 && !rx_overrun, "R6", "five frames fit",
          {rx_overrun, rx_frames}, 5);
      rx_frame(400, 8'hEE, 0, 0);
      chk(rx_frames == 5, "R6", "overflowing frame dropped", rx_frames, 5);
      chk(rx_overrun == 1, "R6", "overrun flag", rx_overrun, 1);
      rd_frame("R6");
      chk(rx_frames == 4, "R6", "count after read", rx_frames, 4);

      // flush
      @(negedge clk); rx_flush = 1'b1;
      @(negedge clk); rx_flush = 1'b0;
      chk(rx_frames == 0 && !rx_overrun, "R7", "flush state",
          {rx_overrun, rx_frames}, 0);
      rx_q.delete();
      rx_frame(4, 8'h61, 0, 1);
      rd_frame("R7");

      // transmit with back-pressure
      stall_en = 1'b1;
      base = tx_req_seen;
      tx_load(9, 8'h30);
      tx_go();
      chk(tx_pending == 1, "R9", "pending after start", tx_pending, 1);
      tx_wait();
      chk(tx_q.size() == 0, "R9", "all bytes sent", tx_q.size(), 0);
      chk(tx_req_seen == base + 1, "R11", "tx req pulses", tx_req_seen, base + 1);
      chk(tx_overrun == 0, "R10", "no spurious overrun", tx_overrun, 0);

      // held while disabled, refused write while pending
      tx_enable = 1'b0;
      tx_load(6, 8'h80);
      tx_go();
      repeat (5) @(negedge clk);
      chk(!txl_valid && tx_pending, "R12", "held while disabled",
          {txl_valid, tx_pending}, 1);
      @(negedge clk); dat_wr = 1'b1; dat_wdata = 32'hFFFF_FFFF;
      @(negedge clk); dat_wr = 1'b0;
      chk(tx_overrun == 1, "R10", "overrun on busy write", tx_overrun, 1);
      tx_enable = 1'b1;
      tx_wait();
      chk(tx_q.size() == 0, "R10", "frame unaffected by refused write", tx_q.size(), 0);
      chk(tx_overrun == 1, "R10", "overrun sticky", tx_overrun, 1);

      // buffer reuse from its start
      stall_en = 1'b0;
      base = tx_req_seen;
      tx_load(5, 8'h01);
      tx_go();
      tx_wait();
      chk(tx_q.size() == 0, "R9", "reuse frame sent", tx_q.size(), 0);
      chk(tx_req_seen == base + 1, "R11", "tx req after reuse", tx_req_seen, base + 1);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule